// File: doc/BRIEF.md
# Buck Converter Soft-Start and Fault Supervisor

This block sequences start-up and latches protection faults for a synchronous buck controller. Once the enable level and the supply power-on-reset flag are both high, it starts a digital reference ramp that counts from zero to full scale at a parameter-set rate. It holds the power-good pin pulled down for a fixed delay, then releases it while the output is in regulation. Analog comparators outside the block deliver overvoltage (rising and falling), undervoltage, overcurrent/short-circuit and over-temperature conditions as single-bit flags.

A latched fault turns the converter off. It also drives a 2-bit power-good code that selects one of three open-drain pull-down strengths, so the fault type can be read from the pin. After an overvoltage latch-off, the block keeps toggling a bottom-gate crowbar output with hysteresis until the latch is cleared. Latches clear only when enable drops or the power-on-reset flag falls. Over-temperature pauses switching without latching. With the defaults (125 MHz clock, 10-bit code, 183 clocks per step, 343 750 clocks of power-good delay), the ramp takes about 1.5 ms and the power-good delay about 2.75 ms.

Top module: `softstart_fault_sup`

## Requirements
- R1: Soft-start begins at the first rising clock edge at which both `enable` and `porOk` are sampled high. Before that edge, `pwmEnable`, `refCode` and `pgCode` are all zero.
- R2: Counting the start edge as edge 0, after edge k of soft-start or regulation `refCode` equals min(floor(k / STEP_DIV), 2^CODE_W - 1).
- R3: With no fault, `pgCode` reads 2'b01 (weak pull-down) after edges 0 to PG_DELAY-1. From edge PG_DELAY on, it reads 2'b00 (high impedance) and the block is in regulation.
- R4: Any latched fault forces `pwmEnable` and `refCode` to zero from the latching edge on, until the latch is cleared.
- R5: The latched code is 2'b11 for overcurrent/short-circuit (`ocFlag`) and 2'b10 for overvoltage (`ovRiseFlag`); both are monitored from edge 0. The code is 2'b01 for undervoltage (`uvFlag`), which is monitored only in regulation and is ignored during soft-start.
- R6: While an overvoltage latch is held, `crowbarOn` turns on at each edge where `ovRiseFlag` is high. It turns off at an edge where `ovFallFlag` is high and `ovRiseFlag` is low, and holds otherwise. At all other times `crowbarOn` is zero.
- R7: The first fault to latch decides `pgCode`. Later fault flags are ignored. For simultaneous flags the priority is overcurrent, then overvoltage, then undervoltage.
- R8: When `enable` or `porOk` is low, `pwmEnable`, `crowbarOn`, `refCode` and `pgCode` are zero in the same cycle, without waiting for a clock edge. At the next edge every latch is cleared, so a later rise restarts soft-start from code 0.
- R9: Fault and over-temperature flags sampled while the block is off have no effect on the next start-up.
- R10: `otHotFlag` at an edge suspends `pwmEnable` from that edge on. `otCoolFlag` without `otHotFlag` resumes it. Over-temperature changes neither `pgCode` nor `refCode` and latches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter on/off level |
| porOk | input | 1 | Supply power-on-reset good flag |
| ovRiseFlag | input | 1 | Feedback above rising overvoltage threshold |
| ovFallFlag | input | 1 | Feedback below falling overvoltage threshold |
| uvFlag | input | 1 | Feedback below undervoltage threshold |
| ocFlag | input | 1 | Overcurrent or short-circuit detected |
| otHotFlag | input | 1 | Die temperature above rising limit |
| otCoolFlag | input | 1 | Die temperature below hysteresis limit |
| refCode | output | CODE_W | Reference ramp code to the DAC |
| pwmEnable | output | 1 | Modulator switching permitted |
| crowbarOn | output | 1 | Force bottom-side gate on |
| pgCode | output | 2 | Power-good pull-down select (00 off, 01 weak, 10 mid, 11 strong) |

## Verification
Two events can land on the same edge: several fault flags at once, and the overvoltage rise and fall flags together while the crowbar cycles. The bench raises overcurrent, overvoltage and undervoltage in one cycle and expects 2'b11 with the crowbar off. It then raises overvoltage and undervoltage together and expects 2'b10 with the crowbar on. Inside an overvoltage latch, it raises both hysteresis flags on one edge and expects the crowbar on. The bench also drops enable between edges and checks that the outputs go quiet before the next clock arrives.

// File: rtl/ssfs_pkg.sv
package ssfs_pkg;
  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_SOFT  = 2'd1,
    PH_REG   = 2'd2,
    PH_LATCH = 2'd3
  } phase_t;

  typedef struct packed {
    logic clear;
    logic advance;
  } dpStrobe_t;

  localparam logic [1:0] PG_HIZ    = 2'b00;
  localparam logic [1:0] PG_WEAK   = 2'b01;
  localparam logic [1:0] PG_MID    = 2'b10;
  localparam logic [1:0] PG_STRONG = 2'b11;
endpackage

// File: rtl/ssfs_ramp_timer.sv
module ssfs_ramp_timer
  import ssfs_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int STEP_DIV = 183,
  parameter int PG_DELAY = 343750
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  output logic [CODE_W-1:0] rampCode,
  output logic              delayDone
);
  localparam logic [CODE_W-1:0] FULL_CODE = {CODE_W{1'b1}};
  localparam int DLY_W = (PG_DELAY > 2) ? $clog2(PG_DELAY) : 1;
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(PG_DELAY - 1);

  logic stepTick;
  logic [DLY_W-1:0] dlyCnt;

  // Step prescaler: absent when every clock advances the code
  generate
    if (STEP_DIV <= 1) begin : g_noDiv
      assign stepTick = strb.advance;
    end else begin : g_div
      localparam int PRE_W = $clog2(STEP_DIV);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STEP_DIV - 1);
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          preCnt <= '0;
        end else if (strb.clear) begin
          preCnt <= '0;
        end else if (strb.advance) begin
          if (preCnt == PRE_LAST) preCnt <= '0;
          else preCnt <= preCnt + 1'b1;
        end
      end
      assign stepTick = strb.advance && (preCnt == PRE_LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rampCode <= '0;
    end else if (strb.clear) begin
      rampCode <= '0;
    end else if (stepTick && (rampCode != FULL_CODE)) begin
      rampCode <= rampCode + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt <= '0;
    end else if (strb.clear) begin
      dlyCnt <= '0;
    end else if (strb.advance && (dlyCnt != DLY_LAST)) begin
      dlyCnt <= dlyCnt + 1'b1;
    end
  end

  assign delayDone = (dlyCnt == DLY_LAST);
endmodule

// File: rtl/ssfs_sequencer.sv
module ssfs_sequencer
  import ssfs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       ovRise,
  input  logic       ovFall,
  input  logic       uvFlag,
  input  logic       ocFlag,
  input  logic       otHot,
  input  logic       otCool,
  input  logic       delayDone,
  output dpStrobe_t  strb,
  output phase_t     phase,
  output logic [1:0] faultCode,
  output logic       crowbarQ,
  output logic       otActive
);
  logic active;
  assign active = (phase == PH_SOFT) || (phase == PH_REG);

  always_comb begin
    strb.clear   = !active;
    strb.advance = active;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_OFF;
      faultCode <= PG_HIZ;
      crowbarQ  <= 1'b0;
    end else if (!run) begin
      phase     <= PH_OFF;
      faultCode <= PG_HIZ;
      crowbarQ  <= 1'b0;
    end else begin
      unique case (phase)
        PH_OFF: phase <= PH_SOFT;
        PH_SOFT: begin
          if (ocFlag) begin
            phase     <= PH_LATCH;
            faultCode <= PG_STRONG;
          end else if (ovRise) begin
            phase     <= PH_LATCH;
            faultCode <= PG_MID;
            crowbarQ  <= 1'b1;
          end else if (delayDone) begin
            phase <= PH_REG;
          end
        end
        PH_REG: begin
          if (ocFlag) begin
            phase     <= PH_LATCH;
            faultCode <= PG_STRONG;
          end else if (ovRise) begin
            phase     <= PH_LATCH;
            faultCode <= PG_MID;
            crowbarQ  <= 1'b1;
          end else if (uvFlag) begin
            phase     <= PH_LATCH;
            faultCode <= PG_WEAK;
          end
        end
        PH_LATCH: begin
          if (faultCode == PG_MID) begin
            if (ovRise) crowbarQ <= 1'b1;
            else if (ovFall) crowbarQ <= 1'b0;
          end
        end
        default: phase <= PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) otActive <= 1'b0;
    else if (!run) otActive <= 1'b0;
    else if (otHot) otActive <= 1'b1;
    else if (otCool) otActive <= 1'b0;
  end
endmodule

// File: rtl/softstart_fault_sup.sv
module softstart_fault_sup
  import ssfs_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int STEP_DIV = 183,
  parameter int PG_DELAY = 343750
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              porOk,
  input  logic              ovRiseFlag,
  input  logic              ovFallFlag,
  input  logic              uvFlag,
  input  logic              ocFlag,
  input  logic              otHotFlag,
  input  logic              otCoolFlag,
  output logic [CODE_W-1:0] refCode,
  output logic              pwmEnable,
  output logic              crowbarOn,
  output logic [1:0]        pgCode
);
  logic              run;
  logic              delayDone;
  logic              crowbarQ;
  logic              otActive;
  logic [1:0]        faultCode;
  logic [CODE_W-1:0] rampCode;
  dpStrobe_t         strb;
  phase_t            phase;

  assign run = enable && porOk;

  ssfs_sequencer u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .run       (run),
    .ovRise    (ovRiseFlag),
    .ovFall    (ovFallFlag),
    .uvFlag    (uvFlag),
    .ocFlag    (ocFlag),
    .otHot     (otHotFlag),
    .otCool    (otCoolFlag),
    .delayDone (delayDone),
    .strb      (strb),
    .phase     (phase),
    .faultCode (faultCode),
    .crowbarQ  (crowbarQ),
    .otActive  (otActive)
  );

  ssfs_ramp_timer #(
    .CODE_W   (CODE_W),
    .STEP_DIV (STEP_DIV),
    .PG_DELAY (PG_DELAY)
  ) u_ramp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rampCode  (rampCode),
    .delayDone (delayDone)
  );

  logic active;
  assign active = (phase == PH_SOFT) || (phase == PH_REG);

  assign pwmEnable = run && active && !otActive;
  assign refCode   = (run && active) ? rampCode : '0;
  assign crowbarOn = run && crowbarQ;

  always_comb begin
    pgCode = PG_HIZ;
    if (run) begin
      unique case (phase)
        PH_SOFT:  pgCode = PG_WEAK;
        PH_LATCH: pgCode = faultCode;
        default:  pgCode = PG_HIZ;
      endcase
    end
  end
endmodule

// File: rtl/ssfs_checker.sv
module ssfs_checker #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              porOk,
  input logic              ovRiseFlag,
  input logic [CODE_W-1:0] refCode,
  input logic              pwmEnable,
  input logic              crowbarOn,
  input logic [1:0]        pgCode
);
  logic run;
  assign run = enable && porOk;

  a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> (!pwmEnable && !crowbarOn && pgCode == 2'b00 && refCode == '0));

  a_r4_latch_no_pwm: assert property (@(posedge clk) disable iff (!rstN)
    pgCode[1] |-> (!pwmEnable && refCode == '0));

  a_r6_crowbar_ov_only: assert property (@(posedge clk) disable iff (!rstN)
    crowbarOn |-> pgCode == 2'b10);

  a_r6_crowbar_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    (run && pgCode == 2'b10 && ovRiseFlag) |=> (crowbarOn || !(enable && porOk)));

  a_r7_strong_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (run && pgCode == 2'b11) |=> (pgCode == 2'b11 || !(enable && porOk)));

  a_r2_ramp_no_down: assert property (@(posedge clk) disable iff (!rstN)
    run |=> (refCode == '0 || refCode >= $past(refCode)));
endmodule

bind softstart_fault_sup ssfs_checker #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .porOk      (porOk),
  .ovRiseFlag (ovRiseFlag),
  .refCode    (refCode),
  .pwmEnable  (pwmEnable),
  .crowbarOn  (crowbarOn),
  .pgCode     (pgCode)
);

// File: tb/softstart_fault_sup_test.sv
module softstart_fault_sup_test;
  localparam int CODE_W   = 3;
  localparam int STEP_DIV = 3;
  localparam int PG_DELAY = 30;
  localparam int FULL     = (1 << CODE_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, porOk = 1'b0;
  logic ovRiseFlag = 1'b0, ovFallFlag = 1'b0, uvFlag = 1'b0, ocFlag = 1'b0;
  logic otHotFlag = 1'b0, otCoolFlag = 1'b0;
  logic [CODE_W-1:0] refCode;
  logic pwmEnable, crowbarOn;
  logic [1:0] pgCode;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  softstart_fault_sup #(
    .CODE_W(CODE_W), .STEP_DIV(STEP_DIV), .PG_DELAY(PG_DELAY)
  ) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .porOk(porOk),
    .ovRiseFlag(ovRiseFlag), .ovFallFlag(ovFallFlag), .uvFlag(uvFlag),
    .ocFlag(ocFlag), .otHotFlag(otHotFlag), .otCoolFlag(otCoolFlag),
    .refCode(refCode), .pwmEnable(pwmEnable), .crowbarOn(crowbarOn),
    .pgCode(pgCode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic outs(input string req, input int code, input int pwm,
                      input int crow, input int pg);
    chk({req, " refCode"}, int'(refCode), code);
    chk({req, " pwmEnable"}, int'(pwmEnable), pwm);
    chk({req, " crowbarOn"}, int'(crowbarOn), crow);
    chk({req, " pgCode"}, int'(pgCode), pg);
  endtask

  // Raise enable/por and sweep every cycle up to regulation (R1, R2, R3)
  task automatic startUp();
    enable = 1'b1;
    porOk = 1'b1;
    #1;
    outs("R1 before start edge", 0, 0, 0, 0);
    @(negedge clk);
    for (int k = 0; k <= PG_DELAY + 1; k++) begin
      int expCode;
      expCode = (k / STEP_DIV > FULL) ? FULL : k / STEP_DIV;
      chk("R2 ramp code", int'(refCode), expCode);
      chk("R3 power-good", int'(pgCode), (k < PG_DELAY) ? 1 : 0);
      chk("R1 pwm on", int'(pwmEnable), 1);
      if (k != PG_DELAY + 1) step();
    end
  endtask

  task automatic shutDown();
    enable = 1'b0;
    #1;
    outs("R8 immediate stop", 0, 0, 0, 0);
    @(negedge clk);
    step();
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    outs("R1 reset state", 0, 0, 0, 0);
    rstN = 1'b1;
    step();

    // R1: enable alone does not start
    enable = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      outs("R1 por low", 0, 0, 0, 0);
    end
    enable = 1'b0;
    step();

    // R9: faults while off ignored
    ocFlag = 1'b1; ovRiseFlag = 1'b1; otHotFlag = 1'b1;
    repeat (3) step();
    outs("R9 flags while off", 0, 0, 0, 0);
    ocFlag = 1'b0; ovRiseFlag = 1'b0; otHotFlag = 1'b0;

    // Full start-up, then overcurrent in regulation (R5, R4)
    startUp();
    ocFlag = 1'b1;
    step();
    ocFlag = 1'b0;
    outs("R5 R4 overcurrent latch", 0, 0, 0, 3);
    uvFlag = 1'b1; ovRiseFlag = 1'b1;
    step();
    uvFlag = 1'b0; ovRiseFlag = 1'b0;
    outs("R7 later faults ignored", 0, 0, 0, 3);
    repeat (4) step();
    outs("R4 latch held", 0, 0, 0, 3);
    shutDown();

    // Overvoltage latch and crowbar hysteresis (R6)
    startUp();
    ovRiseFlag = 1'b1;
    step();
    outs("R5 R6 overvoltage latch", 0, 0, 1, 2);
    ovRiseFlag = 1'b0;
    step();
    outs("R6 crowbar holds", 0, 0, 1, 2);
    ovFallFlag = 1'b1;
    step();
    outs("R6 crowbar off at fall", 0, 0, 0, 2);
    ovFallFlag = 1'b0; ocFlag = 1'b1;
    step();
    ocFlag = 1'b0;
    outs("R7 overcurrent after ov ignored", 0, 0, 0, 2);
    ovRiseFlag = 1'b1; ovFallFlag = 1'b1;
    step();
    outs("R6 rise wins", 0, 0, 1, 2);
    ovRiseFlag = 1'b0;
    step();
    outs("R6 crowbar off again", 0, 0, 0, 2);
    ovFallFlag = 1'b0; ovRiseFlag = 1'b1;
    step();
    ovRiseFlag = 1'b0;
    outs("R6 crowbar recycles", 0, 0, 1, 2);
    // Clear via por fall (R8)
    porOk = 1'b0;
    #1;
    outs("R8 por fall stops", 0, 0, 0, 0);
    @(negedge clk);
    step();
    enable = 1'b0;
    step();

    // Undervoltage ignored in soft-start, latched in regulation (R5)
    enable = 1'b1; porOk = 1'b1;
    step();
    uvFlag = 1'b1;
    repeat (4) step();
    chk("R5 uv ignored in soft-start pg", int'(pgCode), 1);
    chk("R5 uv ignored in soft-start pwm", int'(pwmEnable), 1);
    uvFlag = 1'b0;
    repeat (PG_DELAY) step();
    chk("R3 regulation reached", int'(pgCode), 0);
    uvFlag = 1'b1;
    step();
    uvFlag = 1'b0;
    outs("R5 uv latch", 0, 0, 0, 1);
    shutDown();

    // Overcurrent during soft-start (R5)
    enable = 1'b1; porOk = 1'b1;
    repeat (5) step();
    ocFlag = 1'b1;
    step();
    ocFlag = 1'b0;
    outs("R5 oc in soft-start", 0, 0, 0, 3);
    shutDown();

    // Simultaneous faults (R7)
    startUp();
    ocFlag = 1'b1; ovRiseFlag = 1'b1; uvFlag = 1'b1;
    step();
    ocFlag = 1'b0; ovRiseFlag = 1'b0; uvFlag = 1'b0;
    outs("R7 oc wins", 0, 0, 0, 3);
    shutDown();
    startUp();
    ovRiseFlag = 1'b1; uvFlag = 1'b1;
    step();
    ovRiseFlag = 1'b0; uvFlag = 1'b0;
    outs("R7 ov beats uv", 0, 0, 1, 2);
    shutDown();

    // Over-temperature (R10)
    startUp();
    otHotFlag = 1'b1;
    step();
    otHotFlag = 1'b0;
    outs("R10 ot suspends", FULL, 0, 0, 0);
    step();
    outs("R10 ot held", FULL, 0, 0, 0);
    otHotFlag = 1'b1; otCoolFlag = 1'b1;
    step();
    otHotFlag = 1'b0;
    outs("R10 hot beats cool", FULL, 0, 0, 0);
    step();
    otCoolFlag = 1'b0;
    outs("R10 ot resumes", FULL, 1, 0, 0);
    shutDown();
    enable = 1'b1; porOk = 1'b1;
    step();
    otHotFlag = 1'b1;
    step();
    otHotFlag = 1'b0;
    chk("R10 ot in soft-start pg", int'(pgCode), 1);
    chk("R10 ot in soft-start pwm", int'(pwmEnable), 0);
    shutDown();
    startUp();
    shutDown();

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule